// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical page frame plus its access attributes. Pages are 4 KiB, so the upper 20 address bits form the virtual page number (VPN) and the lower 12 bits pass through unchanged. Entries live in a register array organised as a number of ways, each holding a number of sets. The set is chosen by the low VPN bits. Every way at that set is compared in parallel, and the lowest-numbered way that matches supplies the result.

A stored entry carries a VPN, a global flag, a valid flag, a process identifier and a data word. The data word holds a 20-bit frame number and cacheable, read, write and execute attributes. An entry matches when its VPN equals the lookup VPN and either its global flag is set or its process identifier equals the current one. The valid flag is kept and reported, but it plays no part in matching. Software loads entries through a write port. The lookup result is registered one cycle after the request, and it also says whether the requested access type is permitted.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, every stored entry holds VPN 0, process ID 0, global 0, valid 0, frame 0 and no attributes. A lookup of page 0 with process ID 0 therefore hits way 0 with frame 0 and all attributes clear, while a lookup of page 0 with any other process ID misses. While reset is held, `rsp_valid_o` is low.
- R2: `rsp_valid_o` is high in the cycle after `req_valid_i` was sampled high, and its result fields describe that request.
- R3: The set used by both lookups and writes is VPN modulo `SETS_PER_WAY`. A write with `wr_en_i` high stores into way `wr_way_i` at the set given by the low bits of `wr_vpn_i`.
- R4: A way matches when all 20 stored VPN bits equal the lookup VPN, and either its global flag is 1 or its stored process ID equals `pid_i` across all `PID_W` bits.
- R5: When several ways match, `hit_way_o` and the result fields come from the lowest-numbered matching way.
- R6: On a hit, `pfn_o` and the four attribute outputs come from the selected entry. `paddr_o` is `{pfn_o, vaddr[11:0]}` for every request, hit or miss.
- R7: `access_i` is encoded as 0 for read, 1 for write and 2 for fetch. `allow_o` is high when there is a hit and the read, write or execute attribute respectively is set. Code 3 never allows.
- R8: On a miss, `hit_o`, `allow_o`, `hit_valid_o`, `hit_way_o`, `pfn_o` and all attributes are 0.
- R9: The stored valid flag is not needed for a hit. `hit_valid_o` reports the valid flag of the selected entry.
- R10: A write and a lookup in the same cycle see the contents from before the write. The write becomes visible to the next lookup.
- R11: In a cycle that follows no request, `rsp_valid_o`, `hit_o`, `allow_o` and `paddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address to translate |
| access_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| pid_i | input | PID_W | Current process identifier |
| wr_en_i | input | 1 | Store an entry |
| wr_way_i | input | $clog2(NUM_WAYS) | Way to store into |
| wr_vpn_i | input | 20 | VPN of the new entry (low bits pick the set) |
| wr_pid_i | input | PID_W | Process identifier of the new entry |
| wr_global_i | input | 1 | Global flag of the new entry |
| wr_valid_i | input | 1 | Valid flag of the new entry |
| wr_pfn_i | input | 20 | Frame number of the new entry |
| wr_cache_i | input | 1 | Cacheable attribute |
| wr_read_i | input | 1 | Read attribute |
| wr_write_i | input | 1 | Write attribute |
| wr_exec_i | input | 1 | Execute attribute |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| hit_o | output | 1 | A way matched |
| hit_way_o | output | $clog2(NUM_WAYS) | Selected way |
| hit_valid_o | output | 1 | Valid flag of the selected entry |
| pfn_o | output | 20 | Frame number |
| paddr_o | output | 32 | Physical address |
| perm_cache_o | output | 1 | Cacheable attribute |
| perm_read_o | output | 1 | Read attribute |
| perm_write_o | output | 1 | Write attribute |
| perm_exec_o | output | 1 | Execute attribute |
| allow_o | output | 1 | Requested access is permitted |

## Verification
The hardest case to reach from the ports is two or more ways at the same set holding the same VPN, each matching by a different route: one through the global flag and another through its process ID. Only that case tests the lowest-way priority. Random stimulus draws VPNs from a small pool of high parts, and process IDs from a handful of values, so that writes keep landing duplicate tags across ways. Directed steps add a lower-way copy of an entry that already exists, and a write and lookup to the same entry in one cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned VPN_W     = 32 - PAGE_BITS;
  localparam int unsigned PFN_W     = 20;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } access_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             glob;
    logic             vld;
  } tag_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             cache;
    logic             rd;
    logic             wr;
    logic             ex;
  } data_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS     = 4,
  parameter int unsigned SETS_PER_WAY = 16,
  parameter int unsigned PID_W        = 8,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int unsigned SET_W = (SETS_PER_WAY > 1) ? $clog2(SETS_PER_WAY) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  tag_t             wr_tag_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  data_t            wr_data_i,
  input  logic [SET_W-1:0] rd_set_i,
  output tag_t             rd_tag_o  [NUM_WAYS],
  output logic [PID_W-1:0] rd_pid_o  [NUM_WAYS],
  output data_t            rd_data_o [NUM_WAYS]
);
  tag_t             tag_q  [NUM_WAYS][SETS_PER_WAY];
  logic [PID_W-1:0] pid_q  [NUM_WAYS][SETS_PER_WAY];
  data_t            data_q [NUM_WAYS][SETS_PER_WAY];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS_PER_WAY; s++) begin
          tag_q[w][s]  <= '0;
          pid_q[w][s]  <= '0;
          data_q[w][s] <= '0;
        end
      end else if (wr_en_i && (wr_way_i == WAY_W'(w))) begin
        tag_q[w][wr_set_i]  <= wr_tag_i;
        pid_q[w][wr_set_i]  <= wr_pid_i;
        data_q[w][wr_set_i] <= wr_data_i;
      end
    end

    assign rd_tag_o[w]  = tag_q[w][rd_set_i];
    assign rd_pid_o[w]  = pid_q[w][rd_set_i];
    assign rd_data_o[w] = data_q[w][rd_set_i];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int unsigned PID_W = 8
) (
  input  tag_t             tag_i,
  input  logic [PID_W-1:0] ent_pid_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             match_o,
  output logic             vld_o
);
  logic vpn_eq;
  logic pid_ok;

  // valid flag deliberately excluded from the match
  assign vpn_eq  = (tag_i.vpn == vpn_i);
  assign pid_ok  = tag_i.glob || (ent_pid_i == pid_i);
  assign match_o = vpn_eq && pid_ok;
  assign vld_o   = tag_i.vld;
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] match_i,
  input  logic [NUM_WAYS-1:0] vld_i,
  input  data_t               data_i [NUM_WAYS],
  output logic                hit_o,
  output logic [WAY_W-1:0]    way_o,
  output logic                vld_o,
  output data_t               data_o
);
  // scan high to low so the lowest matching way is assigned last
  always_comb begin
    hit_o  = 1'b0;
    way_o  = '0;
    vld_o  = 1'b0;
    data_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) begin
        hit_o  = 1'b1;
        way_o  = WAY_W'(w);
        vld_o  = vld_i[w];
        data_o = data_i[w];
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS     = 4,
  parameter int unsigned SETS_PER_WAY = 16,
  parameter int unsigned PID_W        = 8,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int unsigned SET_W = (SETS_PER_WAY > 1) ? $clog2(SETS_PER_WAY) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      vaddr_i,
  input  logic [1:0]       access_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [19:0]      wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             wr_global_i,
  input  logic             wr_valid_i,
  input  logic [19:0]      wr_pfn_i,
  input  logic             wr_cache_i,
  input  logic             wr_read_i,
  input  logic             wr_write_i,
  input  logic             wr_exec_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             hit_valid_o,
  output logic [19:0]      pfn_o,
  output logic [31:0]      paddr_o,
  output logic             perm_cache_o,
  output logic             perm_read_o,
  output logic             perm_write_o,
  output logic             perm_exec_o,
  output logic             allow_o
);
  logic [VPN_W-1:0]     lk_vpn;
  logic [SET_W-1:0]     lk_set;
  logic [SET_W-1:0]     wr_set;
  tag_t                 wr_tag;
  data_t                wr_data;
  tag_t                 rd_tag  [NUM_WAYS];
  logic [PID_W-1:0]     rd_pid  [NUM_WAYS];
  data_t                rd_data [NUM_WAYS];
  logic [NUM_WAYS-1:0]  way_match;
  logic [NUM_WAYS-1:0]  way_vld;
  logic                 sel_hit;
  logic [WAY_W-1:0]     sel_way;
  logic                 sel_vld;
  data_t                sel_data;
  logic                 sel_allow;

  assign lk_vpn = vaddr_i[31:PAGE_BITS];
  assign lk_set = SET_W'(lk_vpn);
  assign wr_set = SET_W'(wr_vpn_i);

  assign wr_tag  = '{vpn: wr_vpn_i, glob: wr_global_i, vld: wr_valid_i};
  assign wr_data = '{pfn: wr_pfn_i, cache: wr_cache_i, rd: wr_read_i,
                     wr: wr_write_i, ex: wr_exec_i};

  tlb_entry_array #(
    .NUM_WAYS    (NUM_WAYS),
    .SETS_PER_WAY(SETS_PER_WAY),
    .PID_W       (PID_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_way_i (wr_way_i),
    .wr_set_i (wr_set),
    .wr_tag_i (wr_tag),
    .wr_pid_i (wr_pid_i),
    .wr_data_i(wr_data),
    .rd_set_i (lk_set),
    .rd_tag_o (rd_tag),
    .rd_pid_o (rd_pid),
    .rd_data_o(rd_data)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    tlb_way_match #(.PID_W(PID_W)) u_match (
      .tag_i    (rd_tag[w]),
      .ent_pid_i(rd_pid[w]),
      .vpn_i    (lk_vpn),
      .pid_i    (pid_i),
      .match_o  (way_match[w]),
      .vld_o    (way_vld[w])
    );
  end

  tlb_hit_select #(.NUM_WAYS(NUM_WAYS)) u_sel (
    .match_i(way_match),
    .vld_i  (way_vld),
    .data_i (rd_data),
    .hit_o  (sel_hit),
    .way_o  (sel_way),
    .vld_o  (sel_vld),
    .data_o (sel_data)
  );

  always_comb begin
    unique case (access_e'(access_i))
      ACC_READ:  sel_allow = sel_data.rd;
      ACC_WRITE: sel_allow = sel_data.wr;
      ACC_FETCH: sel_allow = sel_data.ex;
      default:   sel_allow = 1'b0;
    endcase
    sel_allow = sel_allow && sel_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      hit_way_o    <= '0;
      hit_valid_o  <= 1'b0;
      pfn_o        <= '0;
      paddr_o      <= '0;
      perm_cache_o <= 1'b0;
      perm_read_o  <= 1'b0;
      perm_write_o <= 1'b0;
      perm_exec_o  <= 1'b0;
      allow_o      <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      hit_o        <= req_valid_i && sel_hit;
      hit_way_o    <= req_valid_i ? sel_way : '0;
      hit_valid_o  <= req_valid_i && sel_vld;
      pfn_o        <= req_valid_i ? sel_data.pfn : '0;
      paddr_o      <= req_valid_i ? {sel_data.pfn, vaddr_i[PAGE_BITS-1:0]} : '0;
      perm_cache_o <= req_valid_i && sel_data.cache;
      perm_read_o  <= req_valid_i && sel_data.rd;
      perm_write_o <= req_valid_i && sel_data.wr;
      perm_exec_o  <= req_valid_i && sel_data.ex;
      allow_o      <= req_valid_i && sel_allow;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!hit_o && !allow_o && paddr_o == '0)); // R11

  AST_ALLOW_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> hit_o); // R7

  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !hit_o) |-> (pfn_o == '0 && !perm_read_o && !perm_write_o
                                 && !perm_exec_o && !perm_cache_o && !hit_valid_o)); // R8

  AST_PADDR_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (paddr_o[PAGE_BITS-1:0] == $past(vaddr_i[PAGE_BITS-1:0]))); // R6

  AST_PADDR_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (paddr_o[31:PAGE_BITS] == pfn_o)); // R6
endmodule

// File: tb/tlb_lookup_tb_top.sv
module tlb_lookup_tb_top;
  localparam int NW = 4;
  localparam int NS = 16;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [31:0]   vaddr_i = '0;
  logic [1:0]    access_i = '0;
  logic [PW-1:0] pid_i = '0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_way_i = '0;
  logic [19:0]   wr_vpn_i = '0;
  logic [PW-1:0] wr_pid_i = '0;
  logic          wr_global_i = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [19:0]   wr_pfn_i = '0;
  logic          wr_cache_i = 1'b0;
  logic          wr_read_i = 1'b0;
  logic          wr_write_i = 1'b0;
  logic          wr_exec_i = 1'b0;
  logic          rsp_valid_o, hit_o, hit_valid_o, allow_o;
  logic [1:0]    hit_way_o;
  logic [19:0]   pfn_o;
  logic [31:0]   paddr_o;
  logic          perm_cache_o, perm_read_o, perm_write_o, perm_exec_o;

  always #4 clk_i = ~clk_i;

  tlb_lookup #(.NUM_WAYS(NW), .SETS_PER_WAY(NS), .PID_W(PW)) dut_i (.*);

  int n_checks = 0;
  int n_fail = 0;

  // reference model
  logic [19:0]   m_vpn [NW][NS];
  logic [PW-1:0] m_pid [NW][NS];
  logic          m_g   [NW][NS];
  logic          m_v   [NW][NS];
  logic [19:0]   m_pfn [NW][NS];
  logic [3:0]    m_att [NW][NS]; // {c,r,w,x}

  // expected response: {rsp,hit,way[1:0],vld,pfn[19:0],paddr[31:0],c,r,w,x,allow}
  typedef struct packed {
    logic rsp; logic hit; logic [1:0] way; logic vld;
    logic [19:0] pfn; logic [31:0] paddr; logic [3:0] att; logic allow;
  } exp_t;

  function automatic exp_t model_lookup(logic req, logic [31:0] va, logic [1:0] acc,
                                        logic [PW-1:0] pid);
    exp_t e = '0;
    logic [19:0] vpn = va[31:12];
    int s = int'(vpn[3:0]);
    if (!req) return e;
    e.rsp = 1'b1;
    for (int w = 0; w < NW; w++) begin
      if (!e.hit && m_vpn[w][s] == vpn && (m_g[w][s] || m_pid[w][s] == pid)) begin
        e.hit = 1'b1;
        e.way = 2'(w);
        e.vld = m_v[w][s];
        e.pfn = m_pfn[w][s];
        e.att = m_att[w][s];
      end
    end
    e.paddr = {e.pfn, va[11:0]};
    case (acc)
      2'd0: e.allow = e.hit && e.att[2];
      2'd1: e.allow = e.hit && e.att[1];
      2'd2: e.allow = e.hit && e.att[0];
      default: e.allow = 1'b0;
    endcase
    return e;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin
        m_vpn[w][s] = '0; m_pid[w][s] = '0; m_g[w][s] = 1'b0;
        m_v[w][s] = 1'b0; m_pfn[w][s] = '0; m_att[w][s] = '0;
      end
  endtask

  task automatic compare(string tag, exp_t e);
    exp_t a;
    a = '{rsp: rsp_valid_o, hit: hit_o, way: hit_way_o, vld: hit_valid_o, pfn: pfn_o,
          paddr: paddr_o, att: {perm_cache_o, perm_read_o, perm_write_o, perm_exec_o},
          allow: allow_o};
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(string tag, logic req, logic [31:0] va, logic [1:0] acc,
                      logic [PW-1:0] pid, logic we, logic [1:0] way, logic [19:0] vpn,
                      logic [PW-1:0] wpid, logic g, logic v, logic [19:0] pfn,
                      logic [3:0] att);
    exp_t e;
    req_valid_i = req; vaddr_i = va; access_i = acc; pid_i = pid;
    wr_en_i = we; wr_way_i = way; wr_vpn_i = vpn; wr_pid_i = wpid;
    wr_global_i = g; wr_valid_i = v; wr_pfn_i = pfn;
    {wr_cache_i, wr_read_i, wr_write_i, wr_exec_i} = att;
    e = model_lookup(req, va, acc, pid); // R10: old contents
    if (we) begin
      int s = int'(vpn[3:0]);
      m_vpn[way][s] = vpn; m_pid[way][s] = wpid; m_g[way][s] = g;
      m_v[way][s] = v; m_pfn[way][s] = pfn; m_att[way][s] = att;
    end
    @(negedge clk_i);
    compare(tag, e);
  endtask

  task automatic look(string tag, logic [31:0] va, logic [1:0] acc, logic [PW-1:0] pid);
    step(tag, 1'b1, va, acc, pid, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(logic [1:0] way, logic [19:0] vpn, logic [PW-1:0] wpid, logic g,
                    logic v, logic [19:0] pfn, logic [3:0] att);
    step("R3 write", 1'b0, '0, '0, '0, 1'b1, way, vpn, wpid, g, v, pfn, att);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] hi_pool [4];
    void'($urandom(32'h5eed_0001));
    model_reset();
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (rsp_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 rsp during reset actual=%b expected=0", rsp_valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: cleared tags match page 0 / pid 0 only
    look("R1 page0 pid0", 32'h0000_0123, 2'd0, 8'h00);
    look("R1 page0 pid5", 32'h0000_0abc, 2'd0, 8'h05);

    // R6 R9: entry with valid flag clear still hits
    wr(2'd2, 20'h12343, 8'h07, 1'b0, 1'b0, 20'habcde, 4'b0101);
    look("R9 R6 hit no-valid", 32'h1234_3456, 2'd0, 8'h07);
    look("R7 write denied", 32'h1234_3456, 2'd1, 8'h07);
    look("R7 fetch allowed", 32'h1234_3fff, 2'd2, 8'h07);
    look("R7 code3 denied", 32'h1234_3000, 2'd3, 8'h07);
    look("R4 R8 pid mismatch", 32'h1234_3456, 2'd0, 8'h08);
    look("R3 same set other vpn", 32'h1235_3456, 2'd0, 8'h07);

    // R4: global override
    wr(2'd1, 20'h00005, 8'h03, 1'b1, 1'b1, 20'h00777, 4'b1110);
    look("R4 global any pid", 32'h0000_5010, 2'd1, 8'h99);

    // R5: lowest way wins
    wr(2'd3, 20'h12343, 8'h07, 1'b0, 1'b1, 20'h11111, 4'b1111);
    look("R5 way2 over way3", 32'h1234_3456, 2'd1, 8'h07);
    wr(2'd0, 20'h12343, 8'h44, 1'b1, 1'b1, 20'h22222, 4'b0010);
    look("R5 way0 global wins", 32'h1234_3456, 2'd1, 8'h07);

    // R3: set from low vpn bits
    wr(2'd1, 20'h00013, 8'h01, 1'b0, 1'b0, 20'h33333, 4'b0100);
    look("R3 set3 way1", 32'h0001_3800, 2'd0, 8'h01);

    // R10: write and lookup in one cycle
    step("R10 same cycle old", 1'b1, 32'h7777_7123, 2'd0, 8'h01,
         1'b1, 2'd1, 20'h77777, 8'h01, 1'b0, 1'b1, 20'h44444, 4'b0100);
    look("R10 next cycle new", 32'h7777_7123, 2'd0, 8'h01);

    // R11: idle cycle
    step("R11 idle", 1'b0, 32'hffff_ffff, 2'd0, 8'h01, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);

    // random mix with a small tag pool to force multi-way matches (R5)
    hi_pool[0] = 20'h00000; hi_pool[1] = 20'h12340; hi_pool[2] = 20'hfff00;
    hi_pool[3] = 20'h0a0a0;
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] rv, wv;
      logic [31:0] va;
      rv = hi_pool[$urandom_range(0, 3)] | 20'($urandom_range(0, 3));
      wv = hi_pool[$urandom_range(0, 3)] | 20'($urandom_range(0, 3));
      va = {rv, 12'($urandom)};
      step("R4 R5 R6 R7 random", 1'($urandom_range(0, 3) != 0), va, 2'($urandom),
           8'($urandom_range(0, 3)), 1'($urandom_range(0, 2) == 0), 2'($urandom), wv,
           8'($urandom_range(0, 3)), 1'($urandom_range(0, 4) == 0), 1'($urandom),
           20'($urandom), 4'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule